// File: doc/BRIEF.md
# Dual-Rail Precharged Universal Shift Register

This block is a small universal shift register. It can hold its value, shift toward the least significant end, shift toward the most significant end, or load a new word in parallel. Its data path keeps every bit as a pair of complementary rails, and each operation is split into a precharge phase and an evaluate phase. Because of this, the number of rails that switch in a cycle is the same whatever data is being processed.

The phase alternates on every clock. During precharge, the next-state network and the parallel outputs rest at the all-zero spacer. During evaluate, exactly one rail of each pair is high. Data inputs arrive as rail pairs. The single-rail controls (mode, clear, preset) are sampled only on the edge that closes an evaluate phase, which makes one operation take two clocks.

Each storage bit is a master-slave pair. The master holds the state. The slave doubles as the precharged output register. A code monitor raises a sticky flag when it sees a forbidden pair.

Top module: `dual_rail_shifter`

## Requirements
- R1: Synchronous active-high `rst` gives `ev`=0, `q_t`=`q_f`=0, `q_s`=0 and `err`=0. The stored word becomes 0, so the first evaluate phase after reset shows 0.
- R2: A high `clear` at an evaluate-closing edge stores all zeros, whatever `preset`, `mode` and data are.
- R3: A high `preset` with low `clear` stores all ones, whatever `mode` is.
- R4: With `mode`=00, the stored word is unchanged.
- R5: `mode`=01 shifts toward bit 0. Bit i takes bit i+1, and the MSB takes the `sin_r` pair.
- R6: `mode`=10 shifts toward the MSB. Bit i takes bit i-1, and bit 0 takes the `sin_l` pair.
- R7: `mode`=11 stores the `pin` pairs.
- R8: `ev` toggles on every clock after reset. While `ev`=0, `q_t` and `q_f` are all zero (spacer).
- R9: While `ev`=1 with `err` low, every output pair is valid: value 1 is (t=1,f=0) and value 0 is (t=0,f=1). Exactly W rails rise on entering evaluate and none rise on entering precharge. `q_s` equals `q_t` during evaluate.
- R10: Inputs present while `ev`=0 have no effect on the stored word or on `err`.
- R11: `err` goes high one clock after an evaluate-closing edge in either of two cases: any data input pair is (1,1), or the next-state pair chosen by the operation is not complementary, as happens when a consumed input is spacer (0,0). It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 hold, 01 shift toward bit 0, 10 shift toward MSB, 11 load |
| clear | input | 1 | Store all zeros; highest priority |
| preset | input | 1 | Store all ones; below clear |
| sin_l_t | input | 1 | True rail of the bit entering bit 0 |
| sin_l_f | input | 1 | False rail of the bit entering bit 0 |
| sin_r_t | input | 1 | True rail of the bit entering the MSB |
| sin_r_f | input | 1 | False rail of the bit entering the MSB |
| pin_t | input | W | True rails of the parallel word |
| pin_f | input | W | False rails of the parallel word |
| ev | output | 1 | High during the evaluate phase |
| q_t | output | W | True rails of the stored word, spacer in precharge |
| q_f | output | W | False rails of the stored word, spacer in precharge |
| q_s | output | W | Single-rail copy of the stored word |
| err | output | 1 | Sticky flag for a forbidden rail pair |

## Verification
The bench drives random garbage during every precharge phase, including high clear and (1,1) pairs. A design that sampled inputs outside evaluate would then corrupt the word or raise `err`. Clear and preset are applied together, and each is combined with every mode, so a swapped priority would store ones where zeros are due. The serial edge bits are checked separately from the inner bits, because a wrong shift direction or a missing end fill would leave the wrong bit at the MSB or LSB. The rising-rail count is checked at every phase change, which catches any path that leaves a rail high through precharge. Two error cases, one with a (1,1) pair and one with a consumed spacer, check that `err` latches and stays high.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int NOPS    = 6;
  localparam int OP_CLR  = 0;
  localparam int OP_SET  = 1;
  localparam int OP_HOLD = 2;
  localparam int OP_SHR  = 3;
  localparam int OP_SHL  = 4;
  localparam int OP_LOAD = 5;

  typedef enum logic [1:0] {
    MD_HOLD = 2'b00,
    MD_SHR  = 2'b01,
    MD_SHL  = 2'b10,
    MD_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/dr_op_dec.sv
// Turns single-rail controls into one-hot operation lines; all lines low in precharge.
module dr_op_dec
  import dr_pkg::*;
(
  input  logic            ev,
  input  logic [1:0]      mode,
  input  logic            clear,
  input  logic            preset,
  output logic [NOPS-1:0] op
);
  always_comb begin
    op = '0;
    if (ev) begin
      if (clear)       op[OP_CLR] = 1'b1;
      else if (preset) op[OP_SET] = 1'b1;
      else begin
        unique case (mode_e'(mode))
          MD_HOLD: op[OP_HOLD] = 1'b1;
          MD_SHR:  op[OP_SHR]  = 1'b1;
          MD_SHL:  op[OP_SHL]  = 1'b1;
          MD_LOAD: op[OP_LOAD] = 1'b1;
          default: op = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dr_next_net.sv
// Dual-rail AND-OR selection network: one rail per pair rises in evaluate.
module dr_next_net
  import dr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [NOPS-1:0] op,
  input  logic [W-1:0]    m_t,
  input  logic [W-1:0]    m_f,
  input  logic            sl_t,
  input  logic            sl_f,
  input  logic            sr_t,
  input  logic            sr_f,
  input  logic [W-1:0]    p_t,
  input  logic [W-1:0]    p_f,
  output logic [W-1:0]    n_t,
  output logic [W-1:0]    n_f
);
  localparam int MSB = W - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rt, rf, lt, lf;
    if (i == MSB) begin : g_top
      assign rt = sr_t;
      assign rf = sr_f;
    end else begin : g_in
      assign rt = m_t[i+1];
      assign rf = m_f[i+1];
    end
    if (i == 0) begin : g_bot
      assign lt = sl_t;
      assign lf = sl_f;
    end else begin : g_ib
      assign lt = m_t[i-1];
      assign lf = m_f[i-1];
    end
    assign n_t[i] = op[OP_SET] | (op[OP_HOLD] & m_t[i]) | (op[OP_SHR] & rt)
                  | (op[OP_SHL] & lt) | (op[OP_LOAD] & p_t[i]);
    assign n_f[i] = op[OP_CLR] | (op[OP_HOLD] & m_f[i]) | (op[OP_SHR] & rf)
                  | (op[OP_SHL] & lf) | (op[OP_LOAD] & p_f[i]);
  end
endmodule

// File: rtl/dr_ms_cell.sv
// Master-slave storage bit: master holds state, slave is the precharged output.
module dr_ms_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap,
  input  logic n_t,
  input  logic n_f,
  output logic m_t,
  output logic m_f,
  output logic s_t,
  output logic s_f
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_t <= 1'b0;
      m_f <= 1'b1;
    end else if (cap) begin
      m_t <= n_t;
      m_f <= n_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cap) begin
      s_t <= 1'b0;
      s_f <= 1'b0;
    end else begin
      s_t <= m_t;
      s_f <= m_f;
    end
  end
endmodule

// File: rtl/dr_code_mon.sv
// Sticky detector of forbidden rail pairs at evaluate-closing edges.
module dr_code_mon #(
  parameter int NP = 10,
  parameter int W  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  logic [NP-1:0] in_t,
  input  logic [NP-1:0] in_f,
  input  logic [W-1:0]  n_t,
  input  logic [W-1:0]  n_f,
  output logic          err
);
  logic bad_in, bad_net;
  assign bad_in  = |(in_t & in_f);
  assign bad_net = |(~(n_t ^ n_f));

  always_ff @(posedge clk) begin
    if (rst)                         err <= 1'b0;
    else if (ev && (bad_in || bad_net)) err <= 1'b1;
  end
endmodule

// File: rtl/dual_rail_shifter.sv
module dual_rail_shifter
  import dr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic         clear,
  input  logic         preset,
  input  logic         sin_l_t,
  input  logic         sin_l_f,
  input  logic         sin_r_t,
  input  logic         sin_r_f,
  input  logic [W-1:0] pin_t,
  input  logic [W-1:0] pin_f,
  output logic         ev,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f,
  output logic [W-1:0] q_s,
  output logic         err
);
  localparam int NP = W + 2;

  logic            phase_q;
  logic [NOPS-1:0] op;
  logic [W-1:0]    m_t, m_f, nxt_t, nxt_f;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end
  assign ev = phase_q;

  dr_op_dec u_dec (
    .ev(phase_q), .mode(mode), .clear(clear), .preset(preset), .op(op)
  );

  dr_next_net #(.W(W)) u_net (
    .op(op), .m_t(m_t), .m_f(m_f),
    .sl_t(sin_l_t), .sl_f(sin_l_f), .sr_t(sin_r_t), .sr_f(sin_r_f),
    .p_t(pin_t), .p_f(pin_f), .n_t(nxt_t), .n_f(nxt_f)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    dr_ms_cell u_cell (
      .clk(clk), .rst(rst), .cap(phase_q),
      .n_t(nxt_t[i]), .n_f(nxt_f[i]),
      .m_t(m_t[i]), .m_f(m_f[i]),
      .s_t(q_t[i]), .s_f(q_f[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)           q_s <= '0;
    else if (!phase_q) q_s <= m_t;
  end

  dr_code_mon #(.NP(NP), .W(W)) u_mon (
    .clk(clk), .rst(rst), .ev(phase_q),
    .in_t({sin_l_t, sin_r_t, pin_t}), .in_f({sin_l_f, sin_r_f, pin_f}),
    .n_t(nxt_t), .n_f(nxt_f), .err(err)
  );
endmodule

// File: rtl/dual_rail_shifter_chk.sv
module dual_rail_shifter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         ev,
  input logic [1:0]   mode,
  input logic         clear,
  input logic         preset,
  input logic [W-1:0] q_t,
  input logic [W-1:0] q_f,
  input logic [W-1:0] q_s,
  input logic         err,
  input logic [W-1:0] nxt_t,
  input logic [W-1:0] nxt_f
);
  a_r8_phase_toggle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ev != $past(ev)));

  a_r8_spacer: assert property (@(posedge clk) disable iff (rst)
    !ev |-> (q_t == '0 && q_f == '0));

  a_r10_net_spacer: assert property (@(posedge clk) disable iff (rst)
    !ev |-> (nxt_t == '0 && nxt_f == '0));

  a_r9_complement: assert property (@(posedge clk) disable iff (rst)
    (ev && !err) |-> ((q_t & q_f) == '0 && (q_t | q_f) == '1));

  a_r9_single_copy: assert property (@(posedge clk) disable iff (rst)
    ev |-> (q_s == q_t));

  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (ev && clear) |=> ##1 (q_t == '0 && q_f == '1));

  a_r3_preset: assert property (@(posedge clk) disable iff (rst)
    (ev && preset && !clear) |=> ##1 (q_t == '1 && q_f == '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (ev && !clear && !preset && mode == 2'b00 && !err)
      |=> ##1 (q_t == $past(q_t, 2) && q_f == $past(q_f, 2)));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind dual_rail_shifter dual_rail_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ev(ev), .mode(mode), .clear(clear), .preset(preset),
  .q_t(q_t), .q_f(q_f), .q_s(q_s), .err(err), .nxt_t(nxt_t), .nxt_f(nxt_f)
);

// File: tb/test_dual_rail_shifter.sv
module test_dual_rail_shifter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic         clear, preset;
  logic         sin_l_t, sin_l_f, sin_r_t, sin_r_f;
  logic [W-1:0] pin_t, pin_f;
  logic         ev, err;
  logic [W-1:0] q_t, q_f, q_s;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  logic [W-1:0] exp_q = '0;
  logic [W-1:0] pt = '0, pf = '0;
  string last_req = "R1";

  always #10 clk = ~clk;

  dual_rail_shifter #(.W(W)) i_dual_rail_shifter (
    .clk(clk), .rst(rst), .mode(mode), .clear(clear), .preset(preset),
    .sin_l_t(sin_l_t), .sin_l_f(sin_l_f), .sin_r_t(sin_r_t), .sin_r_f(sin_r_f),
    .pin_t(pin_t), .pin_f(pin_f), .ev(ev), .q_t(q_t), .q_f(q_f), .q_s(q_s),
    .err(err)
  );

  function automatic logic [W-1:0] mdl(input logic [W-1:0] s, input logic [1:0] md,
      input logic cl, input logic pr, input logic sl, input logic sr,
      input logic [W-1:0] pv);
    if (cl) return '0;
    if (pr) return '1;
    case (md)
      2'b00:   return s;
      2'b01:   return {sr, s[W-1:1]};
      2'b10:   return {s[W-2:0], sl};
      default: return pv;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int rises();
    return $countones({q_t, q_f} & ~{pt, pf});
  endfunction

  task automatic drive_garbage();
    mode = 2'($urandom); clear = 1'($urandom); preset = 1'($urandom);
    sin_l_t = 1'($urandom); sin_l_f = 1'($urandom);
    sin_r_t = 1'($urandom); sin_r_f = 1'($urandom);
    pin_t = W'($urandom); pin_f = W'($urandom);
  endtask

  // Entry: just after a negedge in precharge. Checks the evaluate view of the
  // word left by the previous operation, then applies this one.
  task automatic step(input logic [1:0] md, input logic cl, input logic pr,
                      input logic sl, input logic sr, input logic [W-1:0] pv,
                      input string req);
    drive_garbage();                          // R10: ignored in precharge
    pt = q_t; pf = q_f;
    @(posedge clk); @(negedge clk);
    chk(ev == 1'b1, "R8", 32'(ev), 1);
    chk(q_t == exp_q, last_req, 32'(q_t), 32'(exp_q));
    chk(q_f == ~exp_q, "R9", 32'(q_f), 32'(~exp_q));
    chk(q_s == exp_q, "R9", 32'(q_s), 32'(exp_q));
    chk(rises() == W, "R9", 32'(rises()), W);
    mode = md; clear = cl; preset = pr;
    sin_l_t = sl; sin_l_f = ~sl; sin_r_t = sr; sin_r_f = ~sr;
    pin_t = pv; pin_f = ~pv;
    pt = q_t; pf = q_f;
    @(posedge clk); @(negedge clk);
    chk(ev == 1'b0, "R8", 32'(ev), 0);
    chk(q_t == '0 && q_f == '0, "R8", 32'({q_t, q_f}), 0);
    chk(rises() == 0, "R9", 32'(rises()), 0);
    chk(err == 1'b0, "R10", 32'(err), 0);
    exp_q = mdl(exp_q, md, cl, pr, sl, sr, pv);
    last_req = req;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(ev == 1'b0 && q_t == '0 && q_f == '0, "R1", 32'({ev, q_t, q_f}), 0);
    chk(q_s == '0 && err == 1'b0, "R1", 32'({q_s, err}), 0);
    rst = 1'b0;
    exp_q = '0;
    last_req = "R1";
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; mode = '0; clear = 0; preset = 0;
    sin_l_t = 0; sin_l_f = 1; sin_r_t = 0; sin_r_f = 1; pin_t = '0; pin_f = '1;
    repeat (2) @(negedge clk);
    do_reset();

    // directed
    step(2'b11, 0, 0, 0, 0, 4'b1010, "R7");
    step(2'b01, 0, 0, 0, 1, 4'b0000, "R5");   // 1010 -> 1101
    step(2'b10, 0, 0, 0, 0, 4'b1111, "R6");   // 1101 -> 1010
    step(2'b10, 0, 0, 1, 0, 4'b0000, "R6");   // 1010 -> 0101
    step(2'b00, 0, 0, 1, 1, 4'b1111, "R4");
    step(2'b00, 0, 0, 0, 0, 4'b0000, "R10");
    step(2'b11, 0, 1, 0, 0, 4'b0000, "R3");
    step(2'b01, 1, 1, 1, 1, 4'b1111, "R2");
    step(2'b11, 1, 0, 1, 1, 4'b1111, "R2");
    step(2'b01, 0, 0, 1, 0, 4'b0000, "R5");   // sin_r enters MSB
    step(2'b01, 0, 0, 0, 0, 4'b0000, "R5");

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [1:0] md;
      logic cl, pr;
      string rq;
      md = 2'($urandom);
      cl = ($urandom % 8) == 0;
      pr = ($urandom % 8) == 0;
      rq = cl ? "R2" : pr ? "R3" : md == 2'b00 ? "R4" : md == 2'b01 ? "R5" :
           md == 2'b10 ? "R6" : "R7";
      step(md, cl, pr, 1'($urandom), 1'($urandom), W'($urandom), rq);
    end
    step(2'b00, 0, 0, 0, 0, 4'b0000, "R4");

    // R11: (1,1) pair on the parallel input during evaluate, mode hold
    @(posedge clk); @(negedge clk);
    mode = 2'b00; clear = 0; preset = 0;
    sin_l_t = 0; sin_l_f = 1; sin_r_t = 0; sin_r_f = 1;
    pin_t = 4'b0001; pin_f = 4'b1111;
    @(posedge clk); @(negedge clk);
    chk(err == 1'b1, "R11", 32'(err), 1);
    pin_f = 4'b1110;
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R11", 32'(err), 1);
    do_reset();

    // R11: consumed spacer on bit 2 under parallel load
    @(posedge clk); @(negedge clk);
    mode = 2'b11; clear = 0; preset = 0;
    pin_t = 4'b1011; pin_f = 4'b0000;
    @(posedge clk); @(negedge clk);
    chk(err == 1'b1, "R11", 32'(err), 1);
    do_reset();
    step(2'b00, 0, 0, 0, 0, 4'b0000, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule